// File: doc/BRIEF.md
# Multichannel Microphone Frame Packer

This block takes one 32-bit sample from each of eight microphone channels once per sample period and turns every such set into a single 256-bit stream beat. A shared strobe, derived from the word-select clock at about 16 kHz, marks when all eight parallel sample words are valid. A small frame buffer captures the set on that strobe. A serialiser then walks the channels in fixed order, one 32-bit word per clock. A packer concatenates the eight words into one AXI4-Stream beat for a DMA engine.

The end-of-packet marker (TLAST) is raised only on every Nth beat, where N is programmable from 1 to 256. One DMA transfer therefore spans many sample periods, and software restarts the transfer far less often. Backpressure from the sink stalls the pipe without loss as long as buffering remains. A frame that arrives when no buffering is left is dropped, and a sticky overflow flag records the loss until software clears it.

Top module: `mic_frame_packer`

## Requirements
- R1: While reset is asserted and after it is released, `m_tvalid`, `m_tlast` and `ovf_flag` are low, and the frame counter starts at zero, so the first TLAST falls on the Nth frame after reset.
- R2: A frame captured at a rising edge (strobe high) appears with `m_tvalid` high after the 8th following rising edge when the output slot is free, and not earlier.
- R3: Channel k is bits [32k+31:32k] of `smp_data`, and the same channel sits in bits [32k+31:32k] of `m_tdata`: channel 0 in [31:0] and channel 7 in [255:224].
- R4: `pkt_frames_m1` holds N-1, so 0 means every beat carries TLAST and 255 means every 256th beat does. TLAST is high on beat N, 2N, 3N and so on.
- R5: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` hold their values. No beat is lost or repeated.
- R6: With the sink stalled, two frames are held (one in the output slot and one in the frame buffer). A third strobe is dropped and sets `ovf_flag`. When the sink resumes, exactly the two held frames come out in arrival order.
- R7: `ovf_flag` is sticky and clears when `ovf_clr` is high at a rising edge. If a drop happens in the same cycle as the clear, the flag ends set.
- R8: A strobe in the same cycle that the last word of the previous frame leaves the frame buffer (8 edges after its capture) is accepted without overflow. A strobe one cycle earlier (7 edges after) is dropped.
- R9: After the beat carrying TLAST the frame counter restarts, so successive packets each hold exactly N beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle strobe: all eight samples are valid |
| smp_data | input | 256 | Eight 32-bit samples, channel k at bits [32k+31:32k] |
| pkt_frames_m1 | input | 8 | Beats per packet minus one |
| ovf_clr | input | 1 | Synchronous clear of the overflow flag |
| m_tready | input | 1 | Stream sink ready |
| m_tvalid | output | 1 | Stream beat valid |
| m_tdata | output | 256 | Stream beat, eight packed samples |
| m_tlast | output | 1 | Last beat of a packet |
| ovf_flag | output | 1 | Sticky overflow: a frame was dropped |

## Verification
On every cycle the assertions check the following. Output data and TLAST stay still during a stall. TLAST never appears without TVALID. A partly serialised frame always has its buffer marked full. A beat is loaded only into a free output slot. A drop always raises the flag, and the flag never falls without a clear. The bench scenarios show what no single-cycle property can: the exact eight-edge latency, the lane placement of each channel, the TLAST spacing for several packet lengths including 1 and 256, the two-frame holding capacity under a stall, and the accept/drop boundary for a strobe arriving 7 or 8 edges after the previous one.

// File: rtl/mfp_pkg.sv
package mfp_pkg;
  localparam int unsigned DEF_NUM_CH = 8;
  localparam int unsigned DEF_SMP_W  = 32;
  localparam int unsigned DEF_CNT_W  = 8;

  typedef enum logic {
    FB_EMPTY = 1'b0,
    FB_FULL  = 1'b1
  } fb_state_e;
endpackage

// File: rtl/mfp_rst_sync.sv
module mfp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mfp_capture.sv
module mfp_capture
  import mfp_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  localparam int unsigned BEAT_W = NUM_CH * SMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [BEAT_W-1:0] data_i,
  input  logic              release_i,
  input  logic              ovf_clr_i,
  output logic [BEAT_W-1:0] data_o,
  output logic              full_o,
  output logic              ovf_o
);
  fb_state_e         st_q, st_d;
  logic              ovf_q, ovf_d;
  logic [BEAT_W-1:0] buf_q;
  logic              accept, drop;

  // A frame may enter while the buffer is empty or while its last word leaves.
  always_comb begin
    accept = stb_i && ((st_q == FB_EMPTY) || release_i);
    drop   = stb_i && !accept;

    st_d = st_q;
    if (accept)         st_d = FB_FULL;
    else if (release_i) st_d = FB_EMPTY;

    ovf_d = ovf_q;
    if (ovf_clr_i) ovf_d = 1'b0;
    if (drop)      ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FB_EMPTY;
      ovf_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) buf_q <= data_i;
  end

  assign data_o = buf_q;
  assign full_o = (st_q == FB_FULL);
  assign ovf_o  = ovf_q;

  // R7
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && full_o && !release_i) |=> ovf_o);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  // R6
  release_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> full_o);
endmodule

// File: rtl/mfp_serializer.sv
module mfp_serializer
  import mfp_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  localparam int unsigned BEAT_W = NUM_CH * SMP_W,
  localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_i,
  input  logic [BEAT_W-1:0] data_i,
  input  logic              out_free_i,
  output logic [SMP_W-1:0]  word_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              adv_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             at_last;

  // One channel word per clock; the final word waits for a free output slot.
  always_comb begin
    at_last = (idx_q == LAST_IDX);
    adv_o   = full_i && (!at_last || out_free_i);
    done_o  = adv_o && at_last;
    idx_d   = idx_q;
    if (adv_o) idx_d = at_last ? '0 : idx_q + 1'b1;
    word_o  = data_i[int'(idx_q)*SMP_W +: SMP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  // R2
  mid_frame_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != '0) |-> full_i);

  // R5
  last_word_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_i && at_last && !out_free_i) |=> (idx_q == LAST_IDX));
endmodule

// File: rtl/mfp_packer.sv
module mfp_packer
  import mfp_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  localparam int unsigned BEAT_W = NUM_CH * SMP_W,
  localparam int unsigned LANE_W = BEAT_W - SMP_W,
  localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SMP_W-1:0]  word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              adv_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  frames_m1_i,
  input  logic              tready_i,
  output logic              tvalid_o,
  output logic [BEAT_W-1:0] tdata_o,
  output logic              tlast_o,
  output logic              out_free_o
);
  logic [LANE_W-1:0] lanes;
  logic              tvalid_q, tvalid_d;
  logic              tlast_q, tlast_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] tdata_q;

  // Holding lanes for every channel but the last, which goes straight to the beat.
  for (genvar k = 0; k < NUM_CH - 1; k++) begin : g_lane
    logic [SMP_W-1:0] lane_q;
    logic             lane_en;
    assign lane_en = adv_i && (idx_i == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (lane_en) lane_q <= word_i;
    end
    assign lanes[k*SMP_W +: SMP_W] = lane_q;
  end

  assign out_free_o = !tvalid_q || tready_i;

  always_comb begin
    tvalid_d = tvalid_q;
    tlast_d  = tlast_q;
    cnt_d    = cnt_q;
    if (done_i) begin
      tvalid_d = 1'b1;
      tlast_d  = (cnt_q >= frames_m1_i);
      cnt_d    = tlast_d ? '0 : cnt_q + 1'b1;
    end else if (tready_i) begin
      tvalid_d = 1'b0;
      tlast_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tvalid_q <= 1'b0;
      tlast_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      tvalid_q <= tvalid_d;
      tlast_q  <= tlast_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (done_i) tdata_q <= {word_i, lanes};
  end

  assign tvalid_o = tvalid_q;
  assign tdata_o  = tdata_q;
  assign tlast_o  = tlast_q;

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid_o && !tready_i) |=> (tvalid_o && $stable(tdata_o) && $stable(tlast_o)));

  // R4
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlast_o |-> tvalid_o);

  // R5
  load_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> out_free_o);
endmodule

// File: rtl/mic_frame_packer.sv
module mic_frame_packer
  import mfp_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned CNT_W  = DEF_CNT_W,
  localparam int unsigned BEAT_W = NUM_CH * SMP_W,
  localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [BEAT_W-1:0] smp_data,
  input  logic [CNT_W-1:0]  pkt_frames_m1,
  input  logic              ovf_clr,
  input  logic              m_tready,
  output logic              m_tvalid,
  output logic [BEAT_W-1:0] m_tdata,
  output logic              m_tlast,
  output logic              ovf_flag
);
  logic              rst_sync_n;
  logic [BEAT_W-1:0] fb_data;
  logic              fb_full;
  logic [SMP_W-1:0]  ser_word;
  logic [IDX_W-1:0]  ser_idx;
  logic              ser_adv, ser_done;
  logic              out_free;

  mfp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mfp_capture #(.NUM_CH(NUM_CH), .SMP_W(SMP_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .stb_i     (smp_stb),
    .data_i    (smp_data),
    .release_i (ser_done),
    .ovf_clr_i (ovf_clr),
    .data_o    (fb_data),
    .full_o    (fb_full),
    .ovf_o     (ovf_flag)
  );

  mfp_serializer #(.NUM_CH(NUM_CH), .SMP_W(SMP_W)) u_ser (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .full_i     (fb_full),
    .data_i     (fb_data),
    .out_free_i (out_free),
    .word_o     (ser_word),
    .idx_o      (ser_idx),
    .adv_o      (ser_adv),
    .done_o     (ser_done)
  );

  mfp_packer #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .CNT_W(CNT_W)) u_pack (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .word_i      (ser_word),
    .idx_i       (ser_idx),
    .adv_i       (ser_adv),
    .done_i      (ser_done),
    .frames_m1_i (pkt_frames_m1),
    .tready_i    (m_tready),
    .tvalid_o    (m_tvalid),
    .tdata_o     (m_tdata),
    .tlast_o     (m_tlast),
    .out_free_o  (out_free)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    (!rst_sync_n) |=> (!m_tvalid && !m_tlast && !ovf_flag));
endmodule

// File: tb/tb_mic_frame_packer.sv
module tb_mic_frame_packer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         smp_stb;
  logic [255:0] smp_data;
  logic [7:0]   pkt_frames_m1;
  logic         ovf_clr;
  logic         m_tready;
  logic         m_tvalid;
  logic [255:0] m_tdata;
  logic         m_tlast;
  logic         ovf_flag;

  always #2 clk = ~clk;

  mic_frame_packer dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
    .pkt_frames_m1(pkt_frames_m1), .ovf_clr(ovf_clr), .m_tready(m_tready),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .ovf_flag(ovf_flag)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Table rows: beats-per-packet minus one, frames to send, sink mode (0 ready, 1 random stall)
  localparam int NVEC = 5;
  localparam int VEC [NVEC][3] = '{
    '{0,   3,   0},
    '{3,   8,   1},
    '{2,   6,   0},
    '{255, 256, 0},
    '{7,   16,  1}
  };

  logic [255:0] exp_q [$];
  int           fid = 1;
  int           cfg_r = 0;
  int           mcnt = 0;
  int           rdy_mode = 0;
  logic [7:0]   lfsr = 8'hA5;
  bit           hold_pend = 0;
  logic [255:0] hold_data;
  logic         hold_last;

  function automatic logic [255:0] fdata(input int id);
    logic [255:0] v;
    for (int ch = 0; ch < 8; ch++)
      v[ch*32 +: 32] = {id[15:0], 8'(ch * 17 + 3), 8'(ch)};
    return v;
  endfunction

  task automatic send_frame(input bit accept);
    @(negedge clk);
    smp_data = fdata(fid);
    smp_stb  = 1'b1;
    if (accept) exp_q.push_back(fdata(fid));
    fid++;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  // Sink model and output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      case (rdy_mode)
        0: m_tready = 1'b1;
        1: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          m_tready = lfsr[0] | lfsr[3];
        end
        default: m_tready = 1'b0;
      endcase
      if (hold_pend)  // R5
        check(m_tvalid && m_tdata == hold_data && m_tlast == hold_last,
              "R5 stalled beat changed", m_tdata, hold_data);
      hold_pend = m_tvalid && !m_tready;
      hold_data = m_tdata;
      hold_last = m_tlast;
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected beat", m_tdata, '0);
        end else begin
          logic [255:0] e;
          bit el;
          e  = exp_q.pop_front();
          el = (mcnt == cfg_r);
          check(m_tdata == e, "R3 beat data", m_tdata, e);
          check(m_tlast == el, "R4 R9 tlast", 256'(m_tlast), 256'(el));
          mcnt = el ? 0 : mcnt + 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    smp_stb = 1'b0;
    smp_data = '0;
    ovf_clr = 1'b0;
    m_tready = 1'b1;
    pkt_frames_m1 = 8'd0;
    repeat (5) @(negedge clk);
    // R1: idle outputs during reset
    check(!m_tvalid && !m_tlast && !ovf_flag, "R1 reset outputs",
          {253'd0, m_tvalid, m_tlast, ovf_flag}, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!m_tvalid && !m_tlast && !ovf_flag, "R1 after release",
          {253'd0, m_tvalid, m_tlast, ovf_flag}, '0);

    // Table walk: data placement (R3), TLAST spacing (R4, R9), stalls (R5)
    for (int r = 0; r < NVEC; r++) begin
      cfg_r = VEC[r][0];
      pkt_frames_m1 = 8'(VEC[r][0]);
      rdy_mode = VEC[r][2];
      for (int f = 0; f < VEC[r][1]; f++) begin
        send_frame(1'b1);
        repeat (18) @(negedge clk);
      end
      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R9 all beats delivered", 256'(exp_q.size()), '0);
      check(!ovf_flag, "R6 no overflow at normal rate", 256'(ovf_flag), '0);
      check(mcnt == 0, "R9 packet boundary", 256'(mcnt), '0);
    end

    rdy_mode = 0;
    cfg_r = 0;
    pkt_frames_m1 = 8'd0;
    repeat (4) @(negedge clk);

    // R2: latency of eight edges
    send_frame(1'b1);
    repeat (7) @(negedge clk);
    check(!m_tvalid, "R2 valid too early", 256'(m_tvalid), '0);
    @(negedge clk);
    check(m_tvalid, "R2 valid after 8 edges", 256'(m_tvalid), 256'(1));
    check(m_tdata[255:224] == fdata(fid - 1)[255:224], "R3 channel 7 lane",
          m_tdata[255:224], fdata(fid - 1)[255:224]);
    check(m_tdata[31:0] == fdata(fid - 1)[31:0], "R3 channel 0 lane",
          m_tdata[31:0], fdata(fid - 1)[31:0]);
    repeat (10) @(negedge clk);

    // R8: strobe exactly when the buffer releases is accepted
    send_frame(1'b1);
    repeat (6) @(negedge clk);
    send_frame(1'b1);
    repeat (30) @(negedge clk);
    check(!ovf_flag, "R8 back-to-back at 8 edges", 256'(ovf_flag), '0);
    check(exp_q.size() == 0, "R8 both frames out", 256'(exp_q.size()), '0);

    // R8: one edge earlier is dropped
    send_frame(1'b1);
    repeat (5) @(negedge clk);
    send_frame(1'b0);
    repeat (30) @(negedge clk);
    check(ovf_flag, "R8 strobe at 7 edges dropped", 256'(ovf_flag), 256'(1));
    check(exp_q.size() == 0, "R8 only first frame out", 256'(exp_q.size()), '0);
    pulse_clr();
    check(!ovf_flag, "R7 clear", 256'(ovf_flag), '0);

    // R6: stalled sink holds two frames, third dropped
    rdy_mode = 2;
    repeat (3) @(negedge clk);
    send_frame(1'b1);
    repeat (15) @(negedge clk);
    send_frame(1'b1);
    repeat (15) @(negedge clk);
    check(!ovf_flag, "R6 two frames fit", 256'(ovf_flag), '0);
    send_frame(1'b0);
    @(negedge clk);
    check(ovf_flag, "R6 third frame sets overflow", 256'(ovf_flag), 256'(1));
    check(m_tvalid, "R5 beat held while stalled", 256'(m_tvalid), 256'(1));
    repeat (5) @(negedge clk);
    check(ovf_flag, "R7 flag sticky", 256'(ovf_flag), 256'(1));
    pulse_clr();
    check(!ovf_flag, "R7 clear while stalled", 256'(ovf_flag), '0);
    // R7: drop and clear in the same cycle leaves the flag set
    @(negedge clk);
    smp_data = fdata(fid);
    fid++;
    smp_stb = 1'b1;
    ovf_clr = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    ovf_clr = 1'b0;
    check(ovf_flag, "R7 set wins over clear", 256'(ovf_flag), 256'(1));
    pulse_clr();
    rdy_mode = 0;
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R6 held frames delivered in order", 256'(exp_q.size()), '0);
    check(!m_tvalid, "R6 nothing extra", 256'(m_tvalid), '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule